// File: doc/BRIEF.md
# Byte-Wide Flash Write-Cycle Front End

This block is the bus-facing half of an emulated byte-wide flash memory with sector erase. A host drives chip-enable, write-enable and output-enable (all active low), a 19-bit byte address and an 8-bit data path. The block samples these pins with a fast system clock and turns strobe edges into write and read events. It decodes two-write command sequences for byte program and sector erase. It then holds a busy window whose length is set in clock counts.

While the window is open, reads do not return array data. They return end-of-write status instead: bit 7 is the complement of the value being written, and bit 6 flips after every completed read. A host polls either bit to find the end of the write.

A software lock guards the array against stray writes. Seven reads at a fixed, parameterized list of addresses turn the lock on or off. While the lock is on, every write is dropped. The array is a small synchronous RAM that is addressed by the low address bits.

Top module: `flash_bus_front`

## Requirements
- R1: A bus write exists only while chip-enable and write-enable are both low; its address is taken when the later of the two strobes falls, and later address changes within the same write have no effect.
- R2: Write data is taken when the earlier of chip-enable and write-enable rises; changes to the data after that point within the same cycle have no effect.
- R3: A write with data 8'h10 followed by a second write stores the second write's data at its address (low MEM_AW bits of the address) and opens a busy window of PROG_CYC clocks.
- R4: A write with data 8'h20 followed by a write with data 8'hD0 sets all 256 bytes of the sector holding the second write's address (array address bits above bit 7) to 8'hFF, opens a busy window of ERASE_CYC clocks, and leaves other sectors unchanged.
- R5: During a busy window a read returns bit 7 as the complement of bit 7 of the value being written (8'hFF for an erase, so 0), with bits 5..0 at zero.
- R6: Bit 6 of a read during a busy window is 0 for the first read after the operation starts and flips after each completed read.
- R7: Once the busy window closes, reads return the array contents.
- R8: Writes that end while a busy window is open are ignored and leave the command state untouched.
- R9: Read addresses are taken when the earlier of output-enable and chip-enable rises. Six consecutive reads at 19'h0A5A5, 19'h05A5A, 19'h3C3C3, 19'h4C3C3, 19'h01234, 19'h7FEDC, followed by a seventh read at 19'h00F0F, turn the lock on; the same six reads followed by 19'h0F0F0 turn it off.
- R10: The lock is off after reset; while it is on, writes neither change the array nor open a busy window.
- R11: A read that does not match the next expected address, or any completed write, restarts the seven-read sequence.
- R12: The data output enable is high only while chip-enable and output-enable are low with write-enable high, and is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low reset |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write strobe, active low |
| bus_oe_n | input | 1 | Read strobe, active low |
| bus_addr | input | 19 | Byte address |
| bus_din | input | 8 | Data from host |
| bus_dout | output | 8 | Data or status to host |
| bus_dout_en | output | 1 | Drive enable for the data path |

## Verification
If the command state is wrong, the array contents become wrong. This shows up at the first read after the busy window, which is PROG_CYC or ERASE_CYC clocks after the write. If the busy state or the toggle state is wrong, it shows up within a single read, because the status byte replaces the array data on every read made during the window. If the lock or sequence state is wrong, no read shows it directly. It appears only when a later program is accepted or dropped, so each lock test is followed by a program and two reads.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_PROG  = 2'd1,
        CMD_ERASE = 2'd2
    } cmd_state_e;

    localparam logic [7:0] OP_PROGRAM  = 8'h10;
    localparam logic [7:0] OP_ERASE    = 8'h20;
    localparam logic [7:0] OP_ERASE_GO = 8'hD0;
    localparam logic [7:0] ERASED_BYTE = 8'hFF;
    localparam int         SECTOR_BITS = 8;

endpackage

// File: rtl/flash_fe_strobe.sv
module flash_fe_strobe #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_start,
    output logic wr_end,
    output logic rd_end,
    output logic rd_act
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] lvl;

    assign raw = {oe_n, we_n, ce_n};

    // two or more flops per strobe before any edge logic
    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] sh_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= {sh_q[SYNC_STAGES-2:0], raw[g]};
        end
        assign lvl[g] = sh_q[SYNC_STAGES-1];
    end

    typedef struct packed {
        logic wr_prev;
        logic rd_prev;
    } edge_t;

    edge_t s_d, s_q;
    logic  wr_now, rd_now;

    assign wr_now = ~lvl[0] & ~lvl[1];
    assign rd_now = ~lvl[0] & ~lvl[2] & lvl[1];

    always_comb begin
        s_d         = s_q;
        s_d.wr_prev = wr_now;
        s_d.rd_prev = rd_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_start = wr_now & ~s_q.wr_prev;
    assign wr_end   = ~wr_now & s_q.wr_prev;
    assign rd_end   = ~rd_now & s_q.rd_prev;
    assign rd_act   = rd_now;

endmodule

// File: rtl/flash_fe_prot.sv
module flash_fe_prot #(
    parameter int ADDR_W  = 19,
    parameter int SEQ_LEN = 7,
    parameter logic [(SEQ_LEN-1)*ADDR_W-1:0] SEQ_ADDRS = {
        19'h7FEDC, 19'h01234, 19'h4C3C3, 19'h3C3C3, 19'h05A5A, 19'h0A5A5},
    parameter logic [ADDR_W-1:0] LOCK_ADDR   = 19'h00F0F,
    parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 19'h0F0F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_end,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_end,
    output logic              prot_on
);
    localparam int STEP_W = $clog2(SEQ_LEN);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              on;
    } prot_t;

    prot_t s_d, s_q;

    function automatic logic [ADDR_W-1:0] seq_at(input int idx);
        return SEQ_ADDRS[idx*ADDR_W +: ADDR_W];
    endfunction

    always_comb begin
        s_d = s_q;
        if (wr_end) begin
            s_d.step = '0;
        end else if (rd_end) begin
            if (s_q.step == LAST_STEP) begin
                if (rd_addr == LOCK_ADDR)        s_d.on = 1'b1;
                else if (rd_addr == UNLOCK_ADDR) s_d.on = 1'b0;
                s_d.step = (rd_addr == seq_at(0)) ? STEP_W'(1) : '0;
            end else if (rd_addr == seq_at(int'(s_q.step))) begin
                s_d.step = s_q.step + 1'b1;
            end else begin
                s_d.step = (rd_addr == seq_at(0)) ? STEP_W'(1) : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign prot_on = s_q.on;

endmodule

// File: rtl/flash_fe_ctrl.sv
module flash_fe_ctrl
    import flash_fe_pkg::*;
#(
    parameter int MEM_AW    = 10,
    parameter int PROG_CYC  = 1750,
    parameter int ERASE_CYC = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic              wr_end,
    input  logic              rd_end,
    input  logic [MEM_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              prot_on,
    output logic              busy,
    output logic [7:0]        status,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_waddr,
    output logic [7:0]        mem_wdata
);
    localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int TMR_W   = $clog2(MAX_CYC + 1);
    localparam int SECT_W  = MEM_AW - SECTOR_BITS;

    typedef struct packed {
        cmd_state_e             cmd;
        logic [MEM_AW-1:0]      addr;
        logic                   busy;
        logic [TMR_W-1:0]       tmr;
        logic                   erasing;
        logic [SECTOR_BITS-1:0] idx;
        logic [SECT_W-1:0]      sect;
        logic                   poll7;
        logic                   tog;
        logic                   we;
        logic [MEM_AW-1:0]      waddr;
        logic [7:0]             wdata;
    } ctrl_t;

    ctrl_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.we = 1'b0;
        if (wr_start) s_d.addr = wr_addr;

        if (s_q.busy) begin
            if (s_q.tmr == '0) s_d.busy = 1'b0;
            else               s_d.tmr  = s_q.tmr - 1'b1;
            if (rd_end) s_d.tog = ~s_q.tog;
            if (s_q.erasing) begin
                s_d.we    = 1'b1;
                s_d.waddr = {s_q.sect, s_q.idx};
                s_d.wdata = ERASED_BYTE;
                s_d.idx   = s_q.idx + 1'b1;
                if (s_q.idx == '1) s_d.erasing = 1'b0;
            end
        end else if (wr_end && !prot_on) begin
            unique case (s_q.cmd)
                CMD_IDLE: begin
                    if (wr_data == OP_PROGRAM)    s_d.cmd = CMD_PROG;
                    else if (wr_data == OP_ERASE) s_d.cmd = CMD_ERASE;
                    else                          s_d.cmd = CMD_IDLE;
                end
                CMD_PROG: begin
                    s_d.cmd   = CMD_IDLE;
                    s_d.busy  = 1'b1;
                    s_d.tmr   = TMR_W'(PROG_CYC - 1);
                    s_d.poll7 = ~wr_data[7];
                    s_d.tog   = 1'b0;
                    s_d.we    = 1'b1;
                    s_d.waddr = s_q.addr;
                    s_d.wdata = wr_data;
                end
                CMD_ERASE: begin
                    s_d.cmd = CMD_IDLE;
                    if (wr_data == OP_ERASE_GO) begin
                        s_d.busy    = 1'b1;
                        s_d.tmr     = TMR_W'(ERASE_CYC - 1);
                        s_d.poll7   = ~ERASED_BYTE[7];
                        s_d.tog     = 1'b0;
                        s_d.erasing = 1'b1;
                        s_d.idx     = '0;
                        s_d.sect    = s_q.addr[MEM_AW-1:SECTOR_BITS];
                    end
                end
                default: s_d.cmd = CMD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = s_q.busy;
    assign status    = {s_q.poll7, s_q.tog, 6'b000000};
    assign mem_we    = s_q.we;
    assign mem_waddr = s_q.waddr;
    assign mem_wdata = s_q.wdata;

endmodule

// File: rtl/flash_fe_array.sv
module flash_fe_array #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
        rdata <= cells[raddr];
    end

endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front #(
    parameter int ADDR_W    = 19,
    parameter int MEM_AW    = 10,
    parameter int PROG_CYC  = 1750,
    parameter int ERASE_CYC = 100000,
    parameter int SEQ_LEN   = 7,
    parameter logic [(SEQ_LEN-1)*ADDR_W-1:0] SEQ_ADDRS = {
        19'h7FEDC, 19'h01234, 19'h4C3C3, 19'h3C3C3, 19'h05A5A, 19'h0A5A5},
    parameter logic [ADDR_W-1:0] LOCK_ADDR   = 19'h00F0F,
    parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 19'h0F0F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_we_n,
    input  logic              bus_oe_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_din,
    output logic [7:0]        bus_dout,
    output logic              bus_dout_en
);
    logic              wr_start, wr_end, rd_end, rd_act;
    logic              prot_on, busy, mem_we;
    logic [7:0]        status, mem_wdata, rdata;
    logic [MEM_AW-1:0] mem_waddr;

    flash_fe_strobe #(.SYNC_STAGES(2)) u_strobe (
        .clk(clk), .rst_n(rst_n),
        .ce_n(bus_ce_n), .we_n(bus_we_n), .oe_n(bus_oe_n),
        .wr_start(wr_start), .wr_end(wr_end),
        .rd_end(rd_end), .rd_act(rd_act)
    );

    flash_fe_prot #(
        .ADDR_W(ADDR_W), .SEQ_LEN(SEQ_LEN), .SEQ_ADDRS(SEQ_ADDRS),
        .LOCK_ADDR(LOCK_ADDR), .UNLOCK_ADDR(UNLOCK_ADDR)
    ) u_prot (
        .clk(clk), .rst_n(rst_n),
        .rd_end(rd_end), .rd_addr(bus_addr),
        .wr_end(wr_end), .prot_on(prot_on)
    );

    flash_fe_ctrl #(
        .MEM_AW(MEM_AW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_start(wr_start), .wr_end(wr_end), .rd_end(rd_end),
        .wr_addr(bus_addr[MEM_AW-1:0]), .wr_data(bus_din),
        .prot_on(prot_on), .busy(busy), .status(status),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    flash_fe_array #(.AW(MEM_AW), .DW(8)) u_array (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(bus_addr[MEM_AW-1:0]), .rdata(rdata)
    );

    assign bus_dout    = busy ? status : rdata;
    assign bus_dout_en = rd_act;

endmodule

// File: rtl/flash_fe_checker.sv
module flash_fe_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic prot_on,
    input logic wr_end,
    input logic rd_end,
    input logic mem_we,
    input logic tog
);
    // R3 R4: the array is written only inside a busy window
    a_r3_write_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R8: a busy window opens only on the clock after a write ends
    a_r8_busy_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_end));

    // R10: a write while locked never opens a busy window
    a_r10_locked_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_end && prot_on && !busy) |=> !busy);

    // R6: each completed read during busy flips the toggle bit
    a_r6_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_end) |=> (!busy || (tog != $past(tog))));

endmodule

bind flash_bus_front flash_fe_checker u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .prot_on(prot_on),
    .wr_end(wr_end), .rd_end(rd_end), .mem_we(mem_we), .tog(status[6])
);

// File: tb/tb_flash_bus_front.sv
module tb_flash_bus_front;
    localparam int PC = 60;
    localparam int EC = 400;
    localparam logic [18:0] SQ [6] = '{19'h0A5A5, 19'h05A5A, 19'h3C3C3,
                                       19'h4C3C3, 19'h01234, 19'h7FEDC};
    localparam logic [18:0] LOCK_A   = 19'h00F0F;
    localparam logic [18:0] UNLOCK_A = 19'h0F0F0;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, ce_n, we_n, oe_n;
    logic [18:0] addr;
    logic [7:0]  din;
    logic [7:0]  dout;
    logic        doe;

    flash_bus_front #(.PROG_CYC(PC), .ERASE_CYC(EC)) dut (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n),
        .bus_oe_n(oe_n), .bus_addr(addr), .bus_din(din),
        .bus_dout(dout), .bus_dout_en(doe)
    );

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] exp_q [$];
    logic [7:0] obs_q [$];
    string      tag_q [$];
    event       obs_ev;

    task automatic judge(input logic [7:0] act, input logic [7:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitor: pops expected items and compares with what the bus returned
    initial begin
        forever begin
            @(obs_ev);
            while (obs_q.size() > 0)
                judge(obs_q.pop_front(), exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic bus_write(input logic [18:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; din = d; ce_n = 1'b0;
        repeat (2) @(negedge clk); we_n = 1'b0;
        repeat (5) @(negedge clk); we_n = 1'b1;
        repeat (5) @(negedge clk); ce_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic program_byte(input logic [18:0] a, input logic [7:0] d);
        bus_write(a, 8'h10);
        bus_write(a, d);
    endtask

    // a_start is driven when the read begins, a_end just before it closes
    task automatic bus_read(input logic [18:0] a_start, input logic [18:0] a_end,
                            input bit chk, input logic [7:0] e, input string tag);
        logic [7:0] got;
        @(negedge clk); addr = a_start; ce_n = 1'b0;
        @(negedge clk); oe_n = 1'b0;
        repeat (3) @(negedge clk); addr = a_end;
        repeat (3) @(negedge clk); got = dout;
        oe_n = 1'b1;
        repeat (4) @(negedge clk); ce_n = 1'b1;
        repeat (2) @(negedge clk);
        if (chk) begin
            exp_q.push_back(e);
            tag_q.push_back(tag);
            obs_q.push_back(got);
            ->obs_ev;
        end
    endtask

    task automatic rd(input logic [18:0] a, input logic [7:0] e, input string tag);
        bus_read(a, a, 1'b1, e, tag);
    endtask

    task automatic rd_nc(input logic [18:0] a);
        bus_read(a, a, 1'b0, 8'h00, "");
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        addr = '0; din = '0;
        idle(5);
        rst_n = 1'b1;
        idle(3);
        judge({7'b0, doe}, 8'h00, "R12 enable low after reset");

        // R12: enable high inside a read, low again after
        @(negedge clk); addr = 19'h00064; ce_n = 1'b0;
        @(negedge clk); oe_n = 1'b0;
        repeat (5) @(negedge clk);
        judge({7'b0, doe}, 8'h01, "R12 enable high during read");
        oe_n = 1'b1; repeat (4) @(negedge clk); ce_n = 1'b1; idle(2);
        judge({7'b0, doe}, 8'h00, "R12 enable low after read");

        // R3 R5 R6 R7: program, poll, then true data
        program_byte(19'h00064, 8'h3C);
        rd(19'h00064, 8'h80, "R5 first poll during program");
        rd(19'h00064, 8'hC0, "R6 second poll toggles bit 6");
        idle(PC + 10);
        rd(19'h00064, 8'h3C, "R3 R7 programmed byte after busy");

        program_byte(19'h000C8, 8'h81); idle(PC + 10);
        program_byte(19'h0012C, 8'h5A); idle(PC + 10);
        program_byte(19'h00250, 8'h77); idle(PC + 10);
        rd(19'h0012C, 8'h5A, "R3 sector 1 byte before erase");

        // R4: erase sector 1 (array bits 9..8 = 01)
        bus_write(19'h001AB, 8'h20);
        bus_write(19'h001AB, 8'hD0);
        rd(19'h00100, 8'h00, "R5 poll during erase");
        idle(EC + 20);
        rd(19'h0012C, 8'hFF, "R4 erased byte");
        rd(19'h001FF, 8'hFF, "R4 last byte of sector erased");
        rd(19'h000C8, 8'h81, "R4 sector 0 untouched");
        rd(19'h00250, 8'h77, "R4 sector 2 untouched");

        // R8: a full program issued during busy has no effect
        program_byte(19'h00064, 8'h11);
        bus_write(19'h000C8, 8'h10);
        bus_write(19'h000C8, 8'h00);
        idle(PC + 10);
        rd(19'h000C8, 8'h81, "R8 write during busy ignored");
        rd(19'h00064, 8'h11, "R8 R3 first program kept");

        // R9 R10: lock; the first read moves its address before closing
        bus_read(19'h00000, SQ[0], 1'b0, 8'h00, "");
        for (int i = 1; i < 6; i++) rd_nc(SQ[i]);
        rd_nc(LOCK_A);
        program_byte(19'h000C8, 8'h00);
        rd(19'h000C8, 8'h81, "R10 locked write not busy and ignored");
        idle(PC + 10);
        rd(19'h000C8, 8'h81, "R10 locked array unchanged");

        // R9: unlock
        for (int i = 0; i < 6; i++) rd_nc(SQ[i]);
        rd_nc(UNLOCK_A);
        program_byte(19'h000C8, 8'h42); idle(PC + 10);
        rd(19'h000C8, 8'h42, "R9 unlocked program accepted");

        // R11: mismatch aborts
        for (int i = 0; i < 3; i++) rd_nc(SQ[i]);
        rd_nc(19'h00001);
        for (int i = 3; i < 6; i++) rd_nc(SQ[i]);
        rd_nc(LOCK_A);
        program_byte(19'h000C8, 8'h24); idle(PC + 10);
        rd(19'h000C8, 8'h24, "R11 mismatched read aborts lock");

        // R11: intervening write aborts
        for (int i = 0; i < 3; i++) rd_nc(SQ[i]);
        bus_write(19'h003FF, 8'h00);
        for (int i = 3; i < 6; i++) rd_nc(SQ[i]);
        rd_nc(LOCK_A);
        program_byte(19'h000C8, 8'h99); idle(PC + 10);
        rd(19'h000C8, 8'h99, "R11 write aborts lock sequence");

        // R1 R2: skewed strobes
        program_byte(19'h002A0, 8'h10); idle(PC + 10);
        bus_write(19'h002A0, 8'h10);
        @(negedge clk); addr = 19'h002B0; din = 8'h10; we_n = 1'b0;
        repeat (5) @(negedge clk); addr = 19'h002A0;
        @(negedge clk); ce_n = 1'b0;
        repeat (5) @(negedge clk); addr = 19'h002C0; din = 8'h6E;
        repeat (5) @(negedge clk); ce_n = 1'b1;
        repeat (5) @(negedge clk); din = 8'h01; we_n = 1'b1;
        idle(3);
        idle(PC + 10);
        rd(19'h002A0, 8'h6E, "R1 R2 address at last fall, data at first rise");

        idle(5);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule